// File: doc/BRIEF.md
# Trace buffer write-pointer controller

This block takes a stream of trace bytes and turns it into byte-addressed memory write requests that fill a region of memory. A current write pointer advances by one for every byte written. When the byte just written sits one address below a programmable limit, the pointer reloads from a programmable base address. The limit and the base are both aligned to 4 KB pages. A programmable buffer mode decides what a pointer wrap does: stop collecting, keep going with an interrupt, or keep going silently. A programmable trigger mode decides what a trigger event does: drain the staged bytes and stop, raise the interrupt only, or do nothing.

An ownership input picks which of two enable bits gates the unit: a self-hosted enable or an external enable. While the gating enable is set, the configuration is frozen against register writes, except for the two enable bits. A small four-register interface sets the limit, base, pointer and modes, and reads back the sticky interrupt and collection state. Bytes are held in a shallow staging buffer, so the memory side may stall without losing accepted data.

Top module: `trace_wptr_ctrl`

## Requirements
- R1: After a cold reset, every register reads zero (control, base, pointer, status), `irq` and `wrValid` are 0 and `inReady` is 1.
- R2: With `extMode`=0 the unit is active when the self enable (control bit 0) is 1. With `extMode`=1 it is active when the external enable (control bit 1) is 1. The other bit has no effect.
- R3: While the unit is inactive or stopped, every offered byte is accepted (`inReady`=1) and discarded, and no write request is issued.
- R4: Accepted bytes are written in arrival order, each at the current pointer (register 2), which then advances by one. `wrValid` holds a byte until `wrReady` is seen.
- R5: The limit is control bits [ADDR_W-1:12] shifted left by 12, and the base is register 1 bits [ADDR_W-1:12] shifted left by 12. A write at address limit-1 reloads the pointer with the base.
- R6: Buffer mode 2'b00 (control bits [3:2]): a pointer wrap stops collection and sets the interrupt.
- R7: Buffer mode 2'b01: a pointer wrap sets the interrupt and collection continues.
- R8: Buffer modes 2'b11 and reserved 2'b10: a pointer wrap leaves the interrupt unchanged and collection continues.
- R9: Trigger mode 2'b00 (control bits [5:4]): a trigger holds `inReady` at 0 while the staged bytes drain to memory (status bit 2 = 1), then stops collection and sets the interrupt.
- R10: Trigger mode 2'b01 sets the interrupt and collection continues. Trigger modes 2'b11 and reserved 2'b10 ignore the trigger.
- R11: While the unit is active, a control-register write updates only the two enable bits, and writes to base or pointer are ignored. While it is inactive, all these writes take effect.
- R12: Status bit 0 (the interrupt, also driven on `irq`) stays set until a status write with bit 0 = 0; a hardware set in the same cycle wins. Status bit 1 (stopped) clears once the unit is inactive, so clearing and setting the enable restarts collection.
- R13: In external mode, control bit 6 (physical pointers) reads 1 and `wrPhys` is 1, whatever value is stored.
- R14: A warm reset clears only the self enable. The external enable, the other configuration fields and the pointers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstColdN | input | 1 | Asynchronous cold reset, active low |
| rstWarmN | input | 1 | Asynchronous warm reset, active low; clears the self enable |
| extMode | input | 1 | Ownership mode: 1 external, 0 self-hosted |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 base, 2 pointer, 3 status |
| regWrData | input | ADDR_W | Register write data |
| regRdData | output | ADDR_W | Register read data for `regAddr` |
| inValid | input | 1 | Trace byte offered |
| inByte | input | 8 | Trace byte |
| inReady | output | 1 | Trace byte taken when high with `inValid` |
| trigIn | input | 1 | Trigger event, one cycle per event |
| wrValid | output | 1 | Memory write request valid |
| wrAddr | output | ADDR_W | Byte address of the write |
| wrData | output | 8 | Byte to write |
| wrReady | input | 1 | Memory accepts the write this cycle |
| wrPhys | output | 1 | Write address is physical |
| irq | output | 1 | Sticky interrupt status |

## Verification
The bench builds the block with a 32-bit address, 4 KB pages and a four-entry staging buffer. With a 32-bit address, each register fits in one bench word. The base is set one page below the limit and the pointer is started four bytes short of the limit, so each combination of buffer mode and trigger mode reaches a wrap within a handful of bytes. The four-entry buffer lets the bench fill it while the memory side stalls, and then watch the trigger drain with back-pressure and the later switch to the stopped state.

// File: rtl/tbwp_pkg.sv
`timescale 1ns/1ps
package tbwp_pkg;

  localparam int BYTE_W = 8;

  // register select
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_BASE = 2'd1;
  localparam logic [1:0] REG_PTR  = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;

  // control register bit positions
  localparam int CTRL_SELF_EN  = 0;
  localparam int CTRL_EXT_EN   = 1;
  localparam int CTRL_BUF_LSB  = 2;
  localparam int CTRL_TRIG_LSB = 4;
  localparam int CTRL_PHYS     = 6;

  // status register bit positions
  localparam int STAT_IRQ   = 0;
  localparam int STAT_STOP  = 1;
  localparam int STAT_FLUSH = 2;

  typedef enum logic [1:0] {
    BUF_FILL = 2'b00,
    BUF_WRAP = 2'b01,
    BUF_RSVD = 2'b10,
    BUF_CIRC = 2'b11
  } bufMode_e;

  typedef enum logic [1:0] {
    TRG_STOP   = 2'b00,
    TRG_IRQ    = 2'b01,
    TRG_RSVD   = 2'b10,
    TRG_IGNORE = 2'b11
  } trigMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic drop;
    logic ptrLoad;
    logic baseLoad;
    logic limitLoad;
  } dpCtl_t;

endpackage

// File: rtl/tbwp_datapath.sv
`timescale 1ns/1ps
module tbwp_datapath
  import tbwp_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int PAGE_SHIFT  = 12,
  parameter int STAGE_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rstColdN,
  input  dpCtl_t                       ctl,
  input  logic [BYTE_W-1:0]            inByte,
  input  logic [ADDR_W-1:0]            regWrData,
  output logic                         fifoEmpty,
  output logic                         fifoFull,
  output logic [BYTE_W-1:0]            headByte,
  output logic [ADDR_W-1:0]            ptrQ,
  output logic [ADDR_W-1:PAGE_SHIFT]   baseQ,
  output logic [ADDR_W-1:PAGE_SHIFT]   limitQ,
  output logic                         wrapHit
);

  localparam int IDX_W = $clog2(STAGE_DEPTH);
  localparam int CNT_W = IDX_W + 1;

  logic [BYTE_W-1:0] stageMem [STAGE_DEPTH];
  logic [IDX_W-1:0]  rdIdx, wrIdx;
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] limitAddr, baseAddr, ptrNext;

  // staging buffer storage
  always_ff @(posedge clk) begin
    if (ctl.push) stageMem[wrIdx] <= inByte;
  end

  // staging buffer indices and fill level
  always_ff @(posedge clk or negedge rstColdN) begin
    if (!rstColdN) begin
      rdIdx <= '0;
      wrIdx <= '0;
      count <= '0;
    end else if (ctl.drop) begin
      rdIdx <= '0;
      wrIdx <= '0;
      count <= '0;
    end else begin
      if (ctl.push) wrIdx <= wrIdx + IDX_W'(1);
      if (ctl.pop)  rdIdx <= rdIdx + IDX_W'(1);
      case ({ctl.push, ctl.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == CNT_W'(STAGE_DEPTH));
  assign headByte  = stageMem[rdIdx];

  // page-aligned base and limit
  always_ff @(posedge clk or negedge rstColdN) begin
    if (!rstColdN) begin
      baseQ  <= '0;
      limitQ <= '0;
    end else begin
      if (ctl.baseLoad)  baseQ  <= regWrData[ADDR_W-1:PAGE_SHIFT];
      if (ctl.limitLoad) limitQ <= regWrData[ADDR_W-1:PAGE_SHIFT];
    end
  end

  assign limitAddr = {limitQ, {PAGE_SHIFT{1'b0}}};
  assign baseAddr  = {baseQ,  {PAGE_SHIFT{1'b0}}};
  assign ptrNext   = ptrQ + ADDR_W'(1);
  assign wrapHit   = (ptrNext == limitAddr);

  // current write pointer
  always_ff @(posedge clk or negedge rstColdN) begin
    if (!rstColdN) begin
      ptrQ <= '0;
    end else if (ctl.pop) begin
      ptrQ <= wrapHit ? baseAddr : ptrNext;
    end else if (ctl.ptrLoad) begin
      ptrQ <= regWrData;
    end
  end

endmodule

// File: rtl/tbwp_control.sv
`timescale 1ns/1ps
module tbwp_control
  import tbwp_pkg::*;
(
  input  logic              clk,
  input  logic              rstColdN,
  input  logic              rstWarmN,
  input  logic              extMode,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [CTRL_PHYS:0] regWrLow,
  input  logic              inValid,
  input  logic              trigIn,
  input  logic              wrReady,
  input  logic              fifoEmpty,
  input  logic              fifoFull,
  input  logic              wrapHit,
  output dpCtl_t            ctl,
  output logic              inReady,
  output logic              wrValid,
  output logic              irq,
  output logic              stopped,
  output logic              flushing,
  output logic              selfEn,
  output logic              extEn,
  output logic              physQ,
  output bufMode_e          bufMode,
  output trigMode_e         trigMode
);

  logic active, run, accept, pop;
  logic wrapEvt, trigEvt, flushDone, stopNow, irqSet, irqClr;
  logic cfgOpen, wrCtrl, wrBase, wrPtr, wrStat, enRstN;

  assign active  = extMode ? extEn : selfEn;
  assign run     = active && !stopped;
  assign cfgOpen = !active;

  // register write decode
  assign wrCtrl = regWrEn && (regAddr == REG_CTRL);
  assign wrBase = regWrEn && (regAddr == REG_BASE);
  assign wrPtr  = regWrEn && (regAddr == REG_PTR);
  assign wrStat = regWrEn && (regAddr == REG_STAT);
  assign irqClr = wrStat && !regWrLow[STAT_IRQ];

  // input and output handshakes
  assign inReady = !run || (!flushing && !fifoFull);
  assign accept  = inValid && inReady;
  assign wrValid = run && !fifoEmpty;
  assign pop     = wrValid && wrReady;

  // events
  assign wrapEvt   = pop && wrapHit;
  assign trigEvt   = trigIn && run && !flushing;
  assign flushDone = flushing && fifoEmpty;
  assign stopNow   = (wrapEvt && (bufMode == BUF_FILL)) || flushDone;
  assign irqSet    = (wrapEvt && ((bufMode == BUF_FILL) || (bufMode == BUF_WRAP)))
                   || (trigEvt && (trigMode == TRG_IRQ))
                   || flushDone;

  // strobes to the datapath
  always_comb begin
    ctl           = '0;
    ctl.push      = accept && run;
    ctl.pop       = pop;
    ctl.drop      = !active;
    ctl.ptrLoad   = wrPtr && cfgOpen;
    ctl.baseLoad  = wrBase && cfgOpen;
    ctl.limitLoad = wrCtrl && cfgOpen;
  end

  // self enable: cleared by either reset
  assign enRstN = rstColdN & rstWarmN;

  always_ff @(posedge clk or negedge enRstN) begin
    if (!enRstN) begin
      selfEn <= 1'b0;
    end else if (wrCtrl) begin
      selfEn <= regWrLow[CTRL_SELF_EN];
    end
  end

  // external enable and modes: cold reset only
  always_ff @(posedge clk or negedge rstColdN) begin
    if (!rstColdN) begin
      extEn    <= 1'b0;
      physQ    <= 1'b0;
      bufMode  <= BUF_FILL;
      trigMode <= TRG_STOP;
    end else if (wrCtrl) begin
      extEn <= regWrLow[CTRL_EXT_EN];
      if (cfgOpen) begin
        physQ    <= regWrLow[CTRL_PHYS];
        bufMode  <= bufMode_e'(regWrLow[CTRL_BUF_LSB +: 2]);
        trigMode <= trigMode_e'(regWrLow[CTRL_TRIG_LSB +: 2]);
      end
    end
  end

  // collection state
  always_ff @(posedge clk or negedge rstColdN) begin
    if (!rstColdN) begin
      stopped  <= 1'b0;
      flushing <= 1'b0;
    end else if (!active) begin
      stopped  <= 1'b0;
      flushing <= 1'b0;
    end else if (stopNow) begin
      stopped  <= 1'b1;
      flushing <= 1'b0;
    end else if (trigEvt && (trigMode == TRG_STOP)) begin
      flushing <= 1'b1;
    end
  end

  // sticky interrupt
  always_ff @(posedge clk or negedge rstColdN) begin
    if (!rstColdN) begin
      irq <= 1'b0;
    end else if (irqSet) begin
      irq <= 1'b1;
    end else if (irqClr) begin
      irq <= 1'b0;
    end
  end

endmodule

// File: rtl/trace_wptr_ctrl.sv
`timescale 1ns/1ps
module trace_wptr_ctrl
  import tbwp_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int PAGE_SHIFT  = 12,
  parameter int STAGE_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstColdN,
  input  logic              rstWarmN,
  input  logic              extMode,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  input  logic              inValid,
  input  logic [7:0]        inByte,
  output logic              inReady,
  input  logic              trigIn,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  input  logic              wrReady,
  output logic              wrPhys,
  output logic              irq
);

  dpCtl_t                     ctl;
  logic                       fifoEmpty, fifoFull, wrapHit;
  logic                       stopped, flushing, selfEn, extEn, physQ;
  bufMode_e                   bufMode;
  trigMode_e                  trigMode;
  logic [ADDR_W-1:0]          ptrQ;
  logic [ADDR_W-1:PAGE_SHIFT] baseQ, limitQ;
  logic [BYTE_W-1:0]          headByte;

  tbwp_control u_ctrl (
    .clk       (clk),
    .rstColdN  (rstColdN),
    .rstWarmN  (rstWarmN),
    .extMode   (extMode),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrLow  (regWrData[CTRL_PHYS:0]),
    .inValid   (inValid),
    .trigIn    (trigIn),
    .wrReady   (wrReady),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .wrapHit   (wrapHit),
    .ctl       (ctl),
    .inReady   (inReady),
    .wrValid   (wrValid),
    .irq       (irq),
    .stopped   (stopped),
    .flushing  (flushing),
    .selfEn    (selfEn),
    .extEn     (extEn),
    .physQ     (physQ),
    .bufMode   (bufMode),
    .trigMode  (trigMode)
  );

  tbwp_datapath #(
    .ADDR_W      (ADDR_W),
    .PAGE_SHIFT  (PAGE_SHIFT),
    .STAGE_DEPTH (STAGE_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstColdN  (rstColdN),
    .ctl       (ctl),
    .inByte    (inByte),
    .regWrData (regWrData),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .headByte  (headByte),
    .ptrQ      (ptrQ),
    .baseQ     (baseQ),
    .limitQ    (limitQ),
    .wrapHit   (wrapHit)
  );

  assign wrAddr = ptrQ;
  assign wrData = headByte;
  assign wrPhys = extMode | physQ;

  // register read mux
  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_CTRL: begin
        regRdData[ADDR_W-1:PAGE_SHIFT]         = limitQ;
        regRdData[CTRL_PHYS]                   = extMode | physQ;
        regRdData[CTRL_TRIG_LSB +: 2]          = trigMode;
        regRdData[CTRL_BUF_LSB +: 2]           = bufMode;
        regRdData[CTRL_EXT_EN]                 = extEn;
        regRdData[CTRL_SELF_EN]                = selfEn;
      end
      REG_BASE: regRdData[ADDR_W-1:PAGE_SHIFT] = baseQ;
      REG_PTR:  regRdData                      = ptrQ;
      default: begin
        regRdData[STAT_IRQ]   = irq;
        regRdData[STAT_STOP]  = stopped;
        regRdData[STAT_FLUSH] = flushing;
      end
    endcase
  end

endmodule

// File: rtl/trace_wptr_chk.sv
`timescale 1ns/1ps
module trace_wptr_chk #(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12
) (
  input logic                       clk,
  input logic                       rstColdN,
  input logic                       rstWarmN,
  input logic                       extMode,
  input logic                       selfEn,
  input logic                       extEn,
  input logic                       regWrEn,
  input logic [1:0]                 regAddr,
  input logic                       regWrBit0,
  input logic                       inReady,
  input logic                       wrValid,
  input logic                       wrReady,
  input logic                       stopped,
  input logic                       flushing,
  input logic                       irq,
  input logic [1:0]                 bufMode,
  input logic [ADDR_W-1:0]          ptrQ,
  input logic [ADDR_W-1:PAGE_SHIFT] baseQ,
  input logic [ADDR_W-1:PAGE_SHIFT] limitQ
);

  logic unitOn, wrapWrite;
  assign unitOn    = extMode ? extEn : selfEn;
  assign wrapWrite = wrValid && wrReady && ((ptrQ + ADDR_W'(1)) == {limitQ, {PAGE_SHIFT{1'b0}}});

  // R3
  inactive_no_write_chk: assert property (@(posedge clk) disable iff (!rstColdN || !rstWarmN)
    !unitOn |-> !wrValid);

  // R3
  stopped_no_write_chk: assert property (@(posedge clk) disable iff (!rstColdN || !rstWarmN)
    stopped |-> !wrValid);

  // R9
  flush_backpressure_chk: assert property (@(posedge clk) disable iff (!rstColdN || !rstWarmN)
    flushing |-> !inReady);

  // R12
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstColdN)
    (irq && !(regWrEn && regAddr == 2'd3 && !regWrBit0)) |=> irq);

  // R11
  base_lock_chk: assert property (@(posedge clk) disable iff (!rstColdN)
    (unitOn && regWrEn && regAddr == 2'd1) |=> $stable(baseQ));

  // R5
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rstColdN || !rstWarmN)
    wrapWrite |=> (ptrQ == {$past(baseQ), {PAGE_SHIFT{1'b0}}}));

  // R6
  fill_stop_chk: assert property (@(posedge clk) disable iff (!rstColdN || !rstWarmN)
    (wrapWrite && bufMode == 2'b00) |=> (stopped && irq));

endmodule

bind trace_wptr_ctrl trace_wptr_chk #(
  .ADDR_W     (ADDR_W),
  .PAGE_SHIFT (PAGE_SHIFT)
) u_chk (
  .clk       (clk),
  .rstColdN  (rstColdN),
  .rstWarmN  (rstWarmN),
  .extMode   (extMode),
  .selfEn    (selfEn),
  .extEn     (extEn),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrBit0 (regWrData[0]),
  .inReady   (inReady),
  .wrValid   (wrValid),
  .wrReady   (wrReady),
  .stopped   (stopped),
  .flushing  (flushing),
  .irq       (irq),
  .bufMode   (bufMode),
  .ptrQ      (ptrQ),
  .baseQ     (baseQ),
  .limitQ    (limitQ)
);

// File: tb/trace_wptr_ctrl_tb.sv
`timescale 1ns/1ps
module trace_wptr_ctrl_tb;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstColdN, rstWarmN, extMode;
  logic          regWrEn;
  logic [1:0]    regAddr;
  logic [AW-1:0] regWrData, regRdData;
  logic          inValid, inReady, trigIn;
  logic [7:0]    inByte;
  logic          wrValid, wrReady, wrPhys, irq;
  logic [AW-1:0] wrAddr;
  logic [7:0]    wrData;

  always #4 clk = ~clk;

  trace_wptr_ctrl #(.ADDR_W(AW), .PAGE_SHIFT(12), .STAGE_DEPTH(4)) u_dut (
    .clk(clk), .rstColdN(rstColdN), .rstWarmN(rstWarmN), .extMode(extMode),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .inValid(inValid), .inByte(inByte), .inReady(inReady), .trigIn(trigIn),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrReady(wrReady),
    .wrPhys(wrPhys), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  int wrCount = 0;
  logic [AW-1:0] lastAddr = '0;
  logic [7:0]    lastData = '0;

  // memory-side monitor
  always @(posedge clk) begin
    if (wrValid && wrReady) begin
      wrCount++;
      lastAddr = wrAddr;
      lastData = wrData;
    end
  end

  typedef struct packed {
    logic [1:0]  bm;
    logic [1:0]  tm;
    logic [3:0]  nPre;
    logic        doTrig;
    logic [3:0]  nPost;
    logic        expIrq;
    logic        expStop;
    logic [3:0]  expWr;
    logic [15:0] expPtr;
    logic [3:0]  reqId;
  } vec_t;

  // pointer starts at 0x2FFC, limit 0x3000, base 0x2000
  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{2'b00, 2'b11, 4'd3, 1'b0, 4'd0, 1'b0, 1'b0, 4'd3, 16'h2FFF, 4'd4},
    '{2'b00, 2'b11, 4'd6, 1'b0, 4'd0, 1'b1, 1'b1, 4'd4, 16'h2000, 4'd6},
    '{2'b01, 2'b11, 4'd6, 1'b0, 4'd0, 1'b1, 1'b0, 4'd6, 16'h2002, 4'd7},
    '{2'b11, 2'b11, 4'd6, 1'b0, 4'd0, 1'b0, 1'b0, 4'd6, 16'h2002, 4'd8},
    '{2'b10, 2'b11, 4'd6, 1'b0, 4'd0, 1'b0, 1'b0, 4'd6, 16'h2002, 4'd8},
    '{2'b11, 2'b11, 4'd4, 1'b0, 4'd0, 1'b0, 1'b0, 4'd4, 16'h2000, 4'd5},
    '{2'b11, 2'b01, 4'd2, 1'b1, 4'd2, 1'b1, 1'b0, 4'd4, 16'h2000, 4'd10},
    '{2'b11, 2'b00, 4'd2, 1'b1, 4'd2, 1'b1, 1'b1, 4'd2, 16'h2FFE, 4'd9},
    '{2'b11, 2'b11, 4'd2, 1'b1, 4'd2, 1'b0, 1'b0, 4'd4, 16'h2000, 4'd10},
    '{2'b11, 2'b10, 4'd2, 1'b1, 4'd2, 1'b0, 1'b0, 4'd4, 16'h2000, 4'd10}
  };

  function automatic string reqName(input logic [3:0] id);
    case (id)
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic regWr(input logic [1:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [1:0] a, output logic [AW-1:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic sendByte(input logic [7:0] b);
    logic ok;
    @(negedge clk);
    inValid = 1'b1; inByte = b;
    forever begin
      #1 ok = inReady;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic pulseTrig();
    @(negedge clk);
    trigIn = 1'b1;
    @(negedge clk);
    trigIn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [AW-1:0] rd, st, p0;
    int start;
    vec_t v;
    rstColdN = 1'b0; rstWarmN = 1'b1; extMode = 1'b0;
    regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    inValid = 1'b0; inByte = '0; trigIn = 1'b0; wrReady = 1'b1;
    idle(3);
    rstColdN = 1'b1;
    idle(1);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      regRd(2'(a), rd);
      check("R1", "register after reset", rd, 32'h0);
    end
    check("R1", "inReady after reset", 32'(inReady), 32'h1);
    check("R1", "wrValid after reset", 32'(wrValid), 32'h0);
    check("R1", "irq after reset", 32'(irq), 32'h0);

    // R3: disabled unit discards input
    start = wrCount;
    sendByte(8'h55);
    idle(4);
    check("R3", "writes while disabled", 32'(wrCount - start), 32'h0);
    regRd(2'd2, rd);
    check("R3", "pointer while disabled", rd, 32'h0);

    // table of mode combinations
    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      regWr(2'd0, 32'h3000 | 32'({v.tm, v.bm, 2'b00}));
      regWr(2'd1, 32'h2000);
      regWr(2'd2, 32'h2FFC);
      regWr(2'd3, 32'h0);
      start = wrCount;
      regWr(2'd0, 32'h3000 | 32'({v.tm, v.bm, 2'b01}));
      for (int k = 0; k < int'(v.nPre); k++) sendByte(8'(8'h10 + k));
      if (v.doTrig) pulseTrig();
      for (int k = 0; k < int'(v.nPost); k++) sendByte(8'(8'h40 + k));
      idle(12);
      regRd(2'd3, st);
      check(reqName(v.reqId), "irq status", 32'(st[0]), 32'(v.expIrq));
      check(reqName(v.reqId), "stopped status", 32'(st[1]), 32'(v.expStop));
      check(reqName(v.reqId), "write count", 32'(wrCount - start), 32'(v.expWr));
      regRd(2'd2, rd);
      check(reqName(v.reqId), "final pointer", rd, 32'(v.expPtr));
      regWr(2'd0, 32'h3000 | 32'({v.tm, v.bm, 2'b00}));
    end

    // R9: flush with a stalled memory side, then stop
    regWr(2'd0, 32'h300C);
    regWr(2'd1, 32'h2000);
    regWr(2'd2, 32'h2100);
    regWr(2'd3, 32'h0);
    wrReady = 1'b0;
    start = wrCount;
    regWr(2'd0, 32'h300D);
    sendByte(8'hA1);
    sendByte(8'hA2);
    sendByte(8'hA3);
    pulseTrig();
    idle(3);
    check("R4", "wrValid held while stalled", 32'(wrValid), 32'h1);
    check("R4", "first write address", wrAddr, 32'h2100);
    check("R4", "first write data", 32'(wrData), 32'hA1);
    check("R9", "inReady during flush", 32'(inReady), 32'h0);
    regRd(2'd3, st);
    check("R9", "flushing status", 32'(st[2]), 32'h1);
    check("R9", "not yet stopped", 32'(st[1]), 32'h0);
    wrReady = 1'b1;
    idle(8);
    check("R9", "bytes drained", 32'(wrCount - start), 32'h3);
    check("R4", "last drained address", lastAddr, 32'h2102);
    check("R4", "last drained data", 32'(lastData), 32'hA3);
    regRd(2'd3, st);
    check("R9", "stopped after flush", 32'(st[1]), 32'h1);
    check("R9", "irq after flush", 32'(st[0]), 32'h1);

    // R12: restart by toggling the enable
    regWr(2'd0, 32'h300C);
    regWr(2'd0, 32'h300D);
    regRd(2'd3, st);
    check("R12", "stopped cleared by re-enable", 32'(st[1]), 32'h0);
    sendByte(8'hB4);
    idle(4);
    check("R12", "write after restart addr", lastAddr, 32'h2103);
    check("R12", "write after restart data", 32'(lastData), 32'hB4);
    regWr(2'd0, 32'h300C);

    // R12: sticky interrupt clear
    regWr(2'd3, 32'h1);
    regRd(2'd3, st);
    check("R12", "irq kept on write of one", 32'(st[0]), 32'h1);
    regWr(2'd3, 32'h0);
    regRd(2'd3, st);
    check("R12", "irq cleared on write of zero", 32'(st[0]), 32'h0);
    check("R12", "irq pin cleared", 32'(irq), 32'h0);

    // R11: configuration lock while active
    regWr(2'd0, 32'h3004);
    regWr(2'd1, 32'h2000);
    regWr(2'd0, 32'h3005);
    regWr(2'd0, 32'h500D);
    regRd(2'd0, rd);
    check("R11", "control locked", rd, 32'h3005);
    regWr(2'd1, 32'h7000);
    regRd(2'd1, rd);
    check("R11", "base locked", rd, 32'h2000);
    regRd(2'd2, p0);
    regWr(2'd2, 32'h1234);
    regRd(2'd2, rd);
    check("R11", "pointer locked", rd, p0);
    regWr(2'd0, 32'h500C);
    regRd(2'd0, rd);
    check("R11", "enable-only write", rd, 32'h3004);
    regWr(2'd0, 32'h500C);
    regRd(2'd0, rd);
    check("R11", "write when inactive", rd, 32'h500C);

    // R2 and R13: external ownership
    @(negedge clk);
    extMode = 1'b1;
    regWr(2'd0, 32'h3001);
    regWr(2'd2, 32'h2200);
    regRd(2'd0, rd);
    check("R13", "physical bit in external mode", rd, 32'h3041);
    check("R13", "wrPhys in external mode", 32'(wrPhys), 32'h1);
    start = wrCount;
    sendByte(8'hC1);
    idle(4);
    check("R2", "self enable ignored in external mode", 32'(wrCount - start), 32'h0);
    regWr(2'd0, 32'h3002);
    sendByte(8'hC2);
    idle(4);
    check("R2", "external enable writes", 32'(wrCount - start), 32'h1);
    check("R2", "external write address", lastAddr, 32'h2200);

    // R14: warm reset
    regWr(2'd0, 32'h3003);
    @(negedge clk);
    rstWarmN = 1'b0;
    @(negedge clk);
    rstWarmN = 1'b1;
    regRd(2'd0, rd);
    check("R14", "warm reset clears self enable only", rd, 32'h3042);
    @(negedge clk);
    extMode = 1'b0;
    regRd(2'd0, rd);
    check("R14", "fields kept in self-hosted view", rd, 32'h3002);
    check("R13", "wrPhys in self-hosted mode", 32'(wrPhys), 32'h0);

    finishRun();
  end

endmodule